// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Word Link

This block moves an N-bit word between two clocked parties over a channel that has no request wire. Each bit travels on two wires: one wire going high means the bit is 1, and the other going high means the bit is 0. Both wires low is the spacer, which marks that no data is present. The receiver does not wait for a strobe. It watches the rails and decides for itself when a whole word has arrived, and later when the whole channel has gone back to empty.

The transmitter takes a binary word from its user and drives the matching rail pattern. It then waits for the single acknowledge wire to rise, drives the spacer, and waits for acknowledge to fall before it takes another word. This is a four-phase, return-to-zero exchange. The receiver checks every pair for three conditions: a legal code, the spacer, or the forbidden both-high code. It raises acknowledge and emits the decoded word with a one-cycle strobe once every pair holds a legal code. It drops acknowledge once every pair is back at the spacer.

The transmitter rails and the receiver rails are separate ports. In normal use they are wired together, and the receiver acknowledge is wired back to the transmitter. Keeping them apart lets either side face a foreign partner or a faulty channel.

Top module: `dr_link`

## Requirements
- R1: After reset, tx_rails is all zero, rx_ack is 0, rx_valid is 0, rx_err is 0 and tx_ready is 1.
- R2: Bit i of a word occupies rails [2i+1:2i]. A 1 is sent as 10 (rail 2i+1 high) and a 0 as 01 (rail 2i high). The spacer is 00 on every pair.
- R3: The transmitter accepts tx_word only on a clock edge where tx_send is 1 and tx_ready is 1. tx_ready is 1 only when the transmitter is idle with spacer on its rails and tx_ack low. A tx_send while tx_ready is 0 has no effect on tx_rails.
- R4: After accepting a word, the transmitter drives its codeword, starting on the next edge, and holds it unchanged while tx_ack is 0. On the first edge that sees tx_ack high it drives the spacer. It becomes ready again on the first edge that sees tx_ack low.
- R5: rx_ack rises only on an edge where every pair of rx_rails holds 10 or 01. A word with some pairs still at 00 keeps rx_ack at 0.
- R6: Once rx_ack is high, it falls only on an edge where every pair of rx_rails reads 00. A partly returned spacer keeps rx_ack at 1.
- R7: On the edge where rx_ack rises, rx_word takes the decoded word and rx_valid goes high for exactly one cycle.
- R8: A pair reading 11 sets rx_err on the next edge, and rx_err stays set until reset. While any pair reads 11, the word is not complete and rx_ack stays at 0.
- R9: With rails and acknowledge looped back, every word value sent arrives unchanged at rx_word, and the link returns to tx_ready afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word | input | WIDTH | Binary word to send |
| tx_send | input | 1 | Request to send tx_word; taken when tx_ready is 1 |
| tx_ready | output | 1 | Transmitter can take a new word |
| tx_rails | output | 2*WIDTH | Transmitter rail pairs (bit i on [2i+1:2i]) |
| tx_ack | input | 1 | Acknowledge seen by the transmitter |
| rx_rails | input | 2*WIDTH | Rail pairs seen by the receiver |
| rx_ack | output | 1 | Acknowledge driven by the receiver |
| rx_word | output | WIDTH | Last decoded word |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |
| rx_err | output | 1 | Sticky flag for a 11 pair |

## Verification
The receiver checks assume that rx_rails move by the four-phase rules. A word is built up pair by pair from the spacer and held until acknowledge rises. The spacer is then restored and held until acknowledge falls. The only exception is the 11 code, which the receiver must flag rather than complete. The transmitter checks assume that tx_ack moves only in answer to the rails. The stimulus keeps within these rules: it uses the looped-back channel for the exhaustive sweep of all word values, and it drives the rails and acknowledge by hand only in protocol order. The single injected 11 pair is placed last, because the error flag it sets is sticky.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;

  localparam logic [1:0] PAIR_SPACER = 2'b00;
  localparam logic [1:0] PAIR_ZERO   = 2'b01;
  localparam logic [1:0] PAIR_ONE    = 2'b10;
  localparam logic [1:0] PAIR_BAD    = 2'b11;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_DATA   = 2'd1,
    TX_SPACER = 2'd2
  } tx_state_t;

  typedef enum logic {
    RX_EMPTY = 1'b0,
    RX_FULL  = 1'b1
  } rx_state_t;

  function automatic logic [1:0] bit_to_pair(input logic b);
    return b ? PAIR_ONE : PAIR_ZERO;
  endfunction

endpackage

// File: rtl/dr_pair_check.sv
module dr_pair_check
  import dr_link_pkg::*;
(
  input  logic [1:0] pair,
  output logic       is_valid,
  output logic       is_empty,
  output logic       is_bad,
  output logic       bit_val
);
  always_comb begin
    is_valid = (pair == PAIR_ONE) || (pair == PAIR_ZERO);
    is_empty = (pair == PAIR_SPACER);
    is_bad   = (pair == PAIR_BAD);
    bit_val  = (pair == PAIR_ONE);
  end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int WIDTH = 4
) (
  input  logic [2*WIDTH-1:0] rails,
  output logic               all_valid,
  output logic               all_empty,
  output logic               any_bad,
  output logic [WIDTH-1:0]   word
);
  logic [WIDTH-1:0] valid_v;
  logic [WIDTH-1:0] empty_v;
  logic [WIDTH-1:0] bad_v;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pair
    dr_pair_check pair_i (
      .pair     (rails[2*gi+1 -: 2]),
      .is_valid (valid_v[gi]),
      .is_empty (empty_v[gi]),
      .is_bad   (bad_v[gi]),
      .bit_val  (word[gi])
    );
  end

  always_comb begin
    all_valid = &valid_v;
    all_empty = &empty_v;
    any_bad   = |bad_v;
  end
endmodule

// File: rtl/dr_tx.sv
module dr_tx
  import dr_link_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   word,
  input  logic               send,
  input  logic               ack,
  output logic               ready,
  output logic [2*WIDTH-1:0] rails
);
  localparam int RAILS = 2 * WIDTH;

  function automatic logic [RAILS-1:0] encode(input logic [WIDTH-1:0] w);
    logic [RAILS-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[2*i+1 -: 2] = bit_to_pair(w[i]);
    return r;
  endfunction

  function automatic logic code_legal(input logic [RAILS-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WIDTH; i++) ok = ok && (r[2*i] ^ r[2*i+1]);
    return ok;
  endfunction

  tx_state_t state;
  logic      take_word;
  logic      to_spacer;
  logic      to_idle;

  always_comb begin
    ready     = (state == TX_IDLE) && !ack;
    take_word = ready && send;
    to_spacer = (state == TX_DATA) && ack;
    to_idle   = (state == TX_SPACER) && !ack;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      rails <= '0;
    end else begin
      if (take_word) begin
        state <= TX_DATA;
        rails <= encode(word);
      end else if (to_spacer) begin
        state <= TX_SPACER;
        rails <= '0;
      end else if (to_idle) begin
        state <= TX_IDLE;
      end
    end
  end

  assert_tx_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rails != '0) |-> code_legal(rails));

  assert_tx_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rails != '0) && !ack) |=> $stable(rails));

  assert_tx_spacer_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rails == '0) && ($past(rails) != '0)) |-> $past(ack));

  assert_tx_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((rails == '0) && !ack));
endmodule

// File: rtl/dr_rx.sv
module dr_rx
  import dr_link_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_valid,
  input  logic             all_empty,
  input  logic             any_bad,
  input  logic [WIDTH-1:0] dec_word,
  output logic             ack,
  output logic [WIDTH-1:0] word,
  output logic             valid,
  output logic             err
);
  rx_state_t state;
  logic      word_done;
  logic      spacer_done;

  always_comb begin
    word_done   = (state == RX_EMPTY) && all_valid && !any_bad;
    spacer_done = (state == RX_FULL) && all_empty;
    ack         = (state == RX_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_EMPTY;
      word  <= '0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else begin
      valid <= word_done;
      err   <= err | any_bad;
      if (word_done) begin
        state <= RX_FULL;
        word  <= dec_word;
      end else if (spacer_done) begin
        state <= RX_EMPTY;
      end
    end
  end

  assert_rx_rise_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(all_valid));

  assert_rx_fall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> $past(all_empty));

  assert_rx_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_rx_pulse_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ack);

  assert_rx_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_rx_bad_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> !$past(any_bad));
endmodule

// File: rtl/dr_link.sv
module dr_link #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   tx_word,
  input  logic               tx_send,
  output logic               tx_ready,
  output logic [2*WIDTH-1:0] tx_rails,
  input  logic               tx_ack,
  input  logic [2*WIDTH-1:0] rx_rails,
  output logic               rx_ack,
  output logic [WIDTH-1:0]   rx_word,
  output logic               rx_valid,
  output logic               rx_err
);
  logic             cmp_all_valid;
  logic             cmp_all_empty;
  logic             cmp_any_bad;
  logic [WIDTH-1:0] cmp_word;

  dr_tx #(.WIDTH(WIDTH)) tx_i (
    .clk   (clk),
    .rst_n (rst_n),
    .word  (tx_word),
    .send  (tx_send),
    .ack   (tx_ack),
    .ready (tx_ready),
    .rails (tx_rails)
  );

  dr_completion #(.WIDTH(WIDTH)) cmp_i (
    .rails     (rx_rails),
    .all_valid (cmp_all_valid),
    .all_empty (cmp_all_empty),
    .any_bad   (cmp_any_bad),
    .word      (cmp_word)
  );

  dr_rx #(.WIDTH(WIDTH)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_valid (cmp_all_valid),
    .all_empty (cmp_all_empty),
    .any_bad   (cmp_any_bad),
    .dec_word  (cmp_word),
    .ack       (rx_ack),
    .word      (rx_word),
    .valid     (rx_valid),
    .err       (rx_err)
  );
endmodule

// File: tb/dr_link_tb_top.sv
module dr_link_tb_top;
  localparam int W        = 4;
  localparam int CLK_PER  = 10;
  localparam int WD_LIMIT = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [W-1:0]   tx_word = '0;
  logic           tx_send = 1'b0;
  logic           tx_ready;
  logic [2*W-1:0] tx_rails;
  logic           tx_ack;
  logic [2*W-1:0] rx_rails;
  logic           rx_ack;
  logic [W-1:0]   rx_word;
  logic           rx_valid;
  logic           rx_err;

  logic           loop = 1'b1;
  logic [2*W-1:0] man_rails = '0;
  logic           man_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign rx_rails = loop ? tx_rails : man_rails;
  assign tx_ack   = loop ? rx_ack : man_ack;

  always #(CLK_PER/2) clk = ~clk;

  dr_link #(.WIDTH(W)) dut_i (
    .clk (clk), .rst_n (rst_n), .tx_word (tx_word), .tx_send (tx_send),
    .tx_ready (tx_ready), .tx_rails (tx_rails), .tx_ack (tx_ack),
    .rx_rails (rx_rails), .rx_ack (rx_ack), .rx_word (rx_word),
    .rx_valid (rx_valid), .rx_err (rx_err)
  );

  // Bench-side encoding: rail 2i+1 carries the bit, rail 2i its inverse
  function automatic logic [2*W-1:0] exp_rails(input logic [W-1:0] w);
    logic [2*W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (w[i]) r = r | ((2*W)'(2) << (2*i));
      else      r = r | ((2*W)'(1) << (2*i));
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      finish_run();
    end
  end

  initial begin
    int tries;
    bit got;
    logic [2*W-1:0] held;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(tx_rails == '0, "R1 rails", int'(tx_rails), 0);
    check(rx_ack == 1'b0, "R1 ack", int'(rx_ack), 0);
    check(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
    check(rx_err == 1'b0, "R1 err", int'(rx_err), 0);
    check(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);

    // R9 exhaustive loopback, with R2 rail pattern and R7 pulse
    for (int w = 0; w < (1 << W); w++) begin
      tx_word = W'(w);
      tx_send = 1'b1;
      tick();
      tx_send = 1'b0;
      got = 1'b0;
      for (tries = 0; tries < 20 && !got; tries++) begin
        if (rx_valid) got = 1'b1;
        else tick();
      end
      check(got, "R9 arrival", int'(got), 1);
      check(rx_word == W'(w), "R9 word", int'(rx_word), w);
      check(tx_rails == exp_rails(W'(w)), "R2 code", int'(tx_rails), int'(exp_rails(W'(w))));
      tick();
      check(rx_valid == 1'b0, "R7 one cycle", int'(rx_valid), 0);
      got = 1'b0;
      for (tries = 0; tries < 20 && !got; tries++) begin
        if (tx_ready) got = 1'b1;
        else tick();
      end
      check(got && tx_rails == '0, "R9 return", int'(tx_rails), 0);
    end

    // Manual transmitter side
    loop = 1'b0;
    man_ack = 1'b0;
    man_rails = '0;
    tick();
    tx_word = 4'b1010;
    tx_send = 1'b1;
    tick();
    tx_send = 1'b0;
    check(tx_rails == exp_rails(4'b1010), "R2 manual code", int'(tx_rails), int'(exp_rails(4'b1010)));
    check(tx_ready == 1'b0, "R3 busy", int'(tx_ready), 0);
    held = tx_rails;
    tx_word = 4'b0101;
    tx_send = 1'b1;
    repeat (4) tick();
    tx_send = 1'b0;
    check(tx_rails == held, "R3 send ignored, R4 hold", int'(tx_rails), int'(held));
    man_ack = 1'b1;
    tick();
    check(tx_rails == '0, "R4 spacer", int'(tx_rails), 0);
    tx_send = 1'b1;
    tx_word = 4'b0110;
    repeat (3) tick();
    tx_send = 1'b0;
    check(tx_rails == '0 && !tx_ready, "R3 ack high", int'(tx_rails), 0);
    man_ack = 1'b0;
    tick();
    check(tx_ready == 1'b1, "R4 ready again", int'(tx_ready), 1);

    // Manual receiver side: partial word then complete
    man_rails = exp_rails(4'b0110) & 8'b0011_1111;
    repeat (4) tick();
    check(rx_ack == 1'b0, "R5 partial word", int'(rx_ack), 0);
    man_rails = exp_rails(4'b0110);
    tick();
    check(rx_ack == 1'b1 && rx_valid == 1'b1, "R7 strobe", int'({rx_ack, rx_valid}), 3);
    check(rx_word == 4'b0110, "R7 word", int'(rx_word), 6);
    tick();
    check(rx_valid == 1'b0, "R7 one cycle manual", int'(rx_valid), 0);
    man_rails = exp_rails(4'b0110) & 8'b1100_0000;
    repeat (4) tick();
    check(rx_ack == 1'b1, "R6 partial spacer", int'(rx_ack), 1);
    man_rails = '0;
    tick();
    check(rx_ack == 1'b0, "R6 spacer done", int'(rx_ack), 0);
    check(rx_err == 1'b0, "R8 clean so far", int'(rx_err), 0);

    // Illegal 11 pair on bit 1
    man_rails = exp_rails(4'b1001) | 8'b0000_1100;
    repeat (3) tick();
    check(rx_err == 1'b1, "R8 err set", int'(rx_err), 1);
    check(rx_ack == 1'b0 && rx_valid == 1'b0, "R8 blocked", int'({rx_ack, rx_valid}), 0);
    man_rails = exp_rails(4'b1001);
    tick();
    check(rx_ack == 1'b1 && rx_word == 4'b1001, "R8 legal after fix", int'(rx_word), 9);
    man_rails = '0;
    repeat (2) tick();
    check(rx_err == 1'b1 && rx_ack == 1'b0, "R8 sticky", int'({rx_err, rx_ack}), 2);

    done = 1'b1;
    finish_run();
  end
endmodule